// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block encrypts a single 128-bit block under a 128-bit key with the AES-128 cipher. A one-cycle start strobe captures the key and the plaintext together. The engine then runs one cipher round per clock on a single shared round datapath. It derives each round key from the previous one in the same cycle, so no key schedule is stored. The ciphertext is presented with a one-cycle completion strobe. The latency is fixed, so a host can either count cycles or wait for the strobe.

Bytes follow the standard ordering of the cipher. Bits 127..120 of a 128-bit bus carry byte 0 of the state, which is row 0 of column 0. Bytes fill the columns top to bottom. A new start strobe during a run abandons that run and begins again with the new inputs. Synchronous reset returns the engine to idle.

Top module: `aes128_iter_enc`

## Requirements
- R1: Key and plaintext are sampled only on the clock edge where `start_i` is high. Changing `key_i` or `text_i` on any later cycle has no effect on that run's ciphertext.
- R2: If `start_i` is sampled high at rising edge E0 and no later start or reset follows, `done_o` is high in the cycle between edge E11 and edge E12, which is the 12th cycle after the start cycle. `done_o` stays low in every cycle before that.
- R3: `done_o` is high for exactly one clock cycle per completed run.
- R4: While `done_o` is high, `cipher_o` equals the AES-128 encryption of the captured plaintext under the captured key. Bits 127..120 hold byte 0. The key 000102..0f with plaintext 00112233..ff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R5: A start that is sampled while a run is in progress restarts the engine. The earlier run produces no `done_o`, and the new run completes 12 cycles after its own start cycle.
- R6: A synchronous reset drives `done_o` low and `cipher_o` to zero, and abandons any run in progress, which then never raises `done_o`.
- R7: With no start since reset, `done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle start strobe; captures key and plaintext |
| key_i | input | 128 | Cipher key, byte 0 in bits 127..120 |
| text_i | input | 128 | Plaintext block, byte 0 in bits 127..120 |
| done_o | output | 1 | One-cycle completion strobe |
| cipher_o | output | 128 | Ciphertext, guaranteed while done_o is high |

## Verification
The only timed result is the completion strobe with its ciphertext. It is due in the cycle after the eleventh rising edge that follows the edge where the start was sampled. The bench drives on falling edges and samples on the falling edge after each rising edge. It counts these falling edges from the start edge and requires `done_o` low on falling edges 1 to 10, high with the expected ciphertext on falling edge 11, and low again on falling edge 12. For restarts, the count begins again at the second start edge. After a reset, the bench watches a window longer than a full run for a strobe that must not appear.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 32;
  localparam int BLK_W   = 128;
  localparam int NBYTES  = BLK_W / BYTE_W;
  localparam int NCOLS   = BLK_W / WORD_W;
  localparam int NROUNDS = 10;
  localparam int CNT_W   = $clog2(NROUNDS + 2);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BLK_W-1:0]  block_t;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic byte_t gf_dbl(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  // a^254 is the multiplicative inverse (and maps 0 to 0)
  function automatic byte_t gf_inv(input byte_t a);
    byte_t p;
    byte_t r;
    p = a;
    r = 8'h01;
    for (int i = 1; i < BYTE_W; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic byte_t rotl8(input byte_t v, input int n);
    return byte_t'((v << n) | (v >> (BYTE_W - n)));
  endfunction

  function automatic byte_t sbox(input byte_t a);
    byte_t v;
    v = gf_inv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  // round constant for round n (1-based)
  function automatic byte_t rcon(input logic [CNT_W-1:0] n);
    byte_t r;
    r = 8'h01;
    for (int i = 1; i < NROUNDS; i++) begin
      if (i < int'(n)) r = gf_dbl(r);
    end
    return r;
  endfunction

  function automatic word_t mix_col(input word_t c);
    byte_t a0, a1, a2, a3;
    a0 = c[31:24]; a1 = c[23:16]; a2 = c[15:8]; a3 = c[7:0];
    return {gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3,
            gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3)};
  endfunction

endpackage

// File: rtl/aes_seq_ctrl.sv
module aes_seq_ctrl
  import aes_enc_pkg::*;
#(
  parameter int NR = NROUNDS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] rnd_o,
  output logic             step_o,
  output logic             final_o,
  output logic             fin_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(NR);
  localparam logic [CNT_W-1:0] FIN_CNT  = CNT_W'(NR + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(1);
      end else if (busy_q) begin
        if (cnt_q == FIN_CNT) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign rnd_o   = cnt_q;
  assign step_o  = busy_q && (cnt_q <= LAST_RND);
  assign final_o = (cnt_q == LAST_RND);
  assign fin_o   = busy_q && (cnt_q == FIN_CNT);
  assign done_o  = done_q;

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  assert_done_follows_run_R2: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(busy_q));

  assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (busy_q && cnt_q == CNT_W'(1) && !done_q));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !start_i) |=> !done_q);

  assert_reset_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done_q && !busy_q));

endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_enc_pkg::*;
(
  input  block_t rk_i,
  input  byte_t  rcon_i,
  output block_t rk_o
);

  word_t w0, w1, w2, w3;
  word_t rot_w, sub_w, mix_w;
  word_t n0, n1, n2, n3;

  assign w0 = rk_i[127:96];
  assign w1 = rk_i[95:64];
  assign w2 = rk_i[63:32];
  assign w3 = rk_i[31:0];
  assign rot_w = {w3[23:0], w3[31:24]};

  for (genvar b = 0; b < WORD_W / BYTE_W; b++) begin : g_subw
    assign sub_w[WORD_W-1-BYTE_W*b -: BYTE_W] = sbox(rot_w[WORD_W-1-BYTE_W*b -: BYTE_W]);
  end

  assign mix_w = sub_w ^ {rcon_i, 24'h000000};
  assign n0 = w0 ^ mix_w;
  assign n1 = w1 ^ n0;
  assign n2 = w2 ^ n1;
  assign n3 = w3 ^ n2;
  assign rk_o = {n0, n1, n2, n3};

endmodule

// File: rtl/aes_round_fn.sv
module aes_round_fn
  import aes_enc_pkg::*;
(
  input  block_t st_i,
  input  block_t rk_i,
  input  logic   final_i,
  output block_t st_o
);

  block_t sub_b, shf_b, mix_b;

  for (genvar b = 0; b < NBYTES; b++) begin : g_bytes
    localparam int ROW = b % 4;
    localparam int COL = b / 4;
    localparam int SRC = ROW + 4 * ((COL + ROW) % NCOLS);
    assign sub_b[BLK_W-1-BYTE_W*b -: BYTE_W] = sbox(st_i[BLK_W-1-BYTE_W*b -: BYTE_W]);
    assign shf_b[BLK_W-1-BYTE_W*b -: BYTE_W] = sub_b[BLK_W-1-BYTE_W*SRC -: BYTE_W];
  end

  for (genvar c = 0; c < NCOLS; c++) begin : g_cols
    assign mix_b[BLK_W-1-WORD_W*c -: WORD_W] = mix_col(shf_b[BLK_W-1-WORD_W*c -: WORD_W]);
  end

  assign st_o = (final_i ? shf_b : mix_b) ^ rk_i;

endmodule

// File: rtl/aes128_iter_enc.sv
module aes128_iter_enc
  import aes_enc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [127:0] key_i,
  input  logic [127:0] text_i,
  output logic         done_o,
  output logic [127:0] cipher_o
);

  logic             busy_w, step_w, final_w, fin_w, done_w;
  logic [CNT_W-1:0] rnd_w;
  block_t           st_q, rk_q, ct_q;
  block_t           rk_next_w, st_next_w;

  aes_seq_ctrl #(.NR(NROUNDS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_w),
    .rnd_o   (rnd_w),
    .step_o  (step_w),
    .final_o (final_w),
    .fin_o   (fin_w),
    .done_o  (done_w)
  );

  aes_key_step u_key (
    .rk_i   (rk_q),
    .rcon_i (rcon(rnd_w)),
    .rk_o   (rk_next_w)
  );

  aes_round_fn u_round (
    .st_i    (st_q),
    .rk_i    (rk_next_w),
    .final_i (final_w),
    .st_o    (st_next_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
      rk_q <= '0;
      ct_q <= '0;
    end else begin
      if (start_i) begin
        st_q <= text_i ^ key_i;
        rk_q <= key_i;
      end else if (step_w) begin
        st_q <= st_next_w;
        rk_q <= rk_next_w;
      end
      if (fin_w && !start_i) ct_q <= st_q;
    end
  end

  assign done_o   = done_w;
  assign cipher_o = ct_q;

  assert_capture_key_R1: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (rk_q == $past(key_i)));

  assert_capture_text_R1: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (st_q == ($past(text_i) ^ $past(key_i))));

  assert_out_with_done_R4: assert property (@(posedge clk) disable iff (rst)
    (!done_w && busy_w) |=> (done_w || $stable(ct_q)));

  assert_out_reset_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ct_q == '0));

endmodule

// File: tb/aes128_iter_enc_test.sv
module aes128_iter_enc_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [127:0] key_i = '0;
  logic [127:0] text_i = '0;
  logic         done_o;
  logic [127:0] cipher_o;

  int checks = 0;
  int fails  = 0;

  logic [7:0] ex_t [256];
  int         lg_t [256];
  logic [7:0] sb_t [256];

  always #10 clk = ~clk;

  aes128_iter_enc uut (
    .clk(clk), .rst(rst), .start_i(start_i), .key_i(key_i),
    .text_i(text_i), .done_o(done_o), .cipher_o(cipher_o)
  );

  task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] lmul(input logic [7:0] a, input logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return ex_t[(lg_t[a] + lg_t[b]) % 255];
  endfunction

  function automatic logic [7:0] rc_of(input int i);
    case (i)
      0: return 8'h01; 1: return 8'h02; 2: return 8'h04; 3: return 8'h08;
      4: return 8'h10; 5: return 8'h20; 6: return 8'h40; 7: return 8'h80;
      8: return 8'h1b; default: return 8'h36;
    endcase
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] k, input logic [127:0] p);
    logic [7:0] s [16];
    logic [7:0] n [16];
    logic [7:0] w [176];
    logic [7:0] t [4];
    logic [127:0] r;
    for (int i = 0; i < 16; i++) begin
      s[i] = p[127-8*i -: 8];
      w[i] = k[127-8*i -: 8];
    end
    for (int i = 16; i < 176; i += 4) begin
      for (int j = 0; j < 4; j++) t[j] = w[i-4+j];
      if (i % 16 == 0) begin
        logic [7:0] f;
        f = t[0];
        t[0] = sb_t[t[1]] ^ rc_of(i/16 - 1);
        t[1] = sb_t[t[2]];
        t[2] = sb_t[t[3]];
        t[3] = sb_t[f];
      end
      for (int j = 0; j < 4; j++) w[i+j] = w[i-16+j] ^ t[j];
    end
    for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[i];
    for (int rd = 1; rd <= 10; rd++) begin
      for (int i = 0; i < 16; i++) n[i] = sb_t[s[(i%4) + 4*(((i/4) + (i%4)) % 4)]];
      for (int c = 0; c < 4; c++) begin
        if (rd < 10) begin
          for (int q = 0; q < 4; q++)
            s[4*c+q] = lmul(8'h02, n[4*c+q]) ^ lmul(8'h03, n[4*c+(q+1)%4])
                     ^ n[4*c+(q+2)%4] ^ n[4*c+(q+3)%4];
        end else begin
          for (int q = 0; q < 4; q++) s[4*c+q] = n[4*c+q];
        end
      end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[16*rd+i];
    end
    for (int i = 0; i < 16; i++) r[127-8*i -: 8] = s[i];
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // drive a start at a falling edge; returns at the falling edge after the start edge
  task automatic kick(input logic [127:0] k, input logic [127:0] p);
    start_i = 1'b1; key_i = k; text_i = p;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // watch falling edges 1..12 after the start edge; scramble inputs meanwhile (R1)
  task automatic run_and_check(input logic [127:0] k, input logic [127:0] p, input string tag);
    logic [127:0] e;
    e = ref_enc(k, p);
    kick(k, p);
    for (int i = 1; i <= 12; i++) begin
      key_i = rnd128(); text_i = rnd128();
      @(negedge clk);
      if (i < 11) chk({"R2 early done ", tag}, {127'd0, done_o}, 128'd0);
      else if (i == 11) begin
        chk({"R2 done due ", tag}, {127'd0, done_o}, 128'd1);
        chk({"R4 R1 ciphertext ", tag}, cipher_o, e);
      end else chk({"R3 single done ", tag}, {127'd0, done_o}, 128'd0);
    end
  endtask

  initial begin
    begin : wd
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] e;
    logic [127:0] ka, pa, kb, pb;
    void'($urandom(32'd20417));
    e = 8'h01;
    for (int i = 0; i < 256; i++) lg_t[i] = 0;
    for (int i = 0; i < 255; i++) begin
      ex_t[i] = e;
      lg_t[e] = i;
      e = e ^ {e[6:0], 1'b0} ^ (e[7] ? 8'h1b : 8'h00);
    end
    ex_t[255] = 8'h01;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] v, o;
      v = (x == 0) ? 8'h00 : ex_t[(255 - lg_t[x]) % 255];
      for (int b = 0; b < 8; b++)
        o[b] = v[b] ^ v[(b+4)%8] ^ v[(b+5)%8] ^ v[(b+6)%8] ^ v[(b+7)%8];
      sb_t[x] = o ^ 8'h63;
    end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R6 reset done low", {127'd0, done_o}, 128'd0);
    chk("R6 reset cipher zero", cipher_o, 128'd0);

    // R7 idle with no start
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R7 idle no done", {127'd0, done_o}, 128'd0);
    end

    // R4 standard vector, also the bench model self-check
    chk("R4 model vector", ref_enc(128'h000102030405060708090a0b0c0d0e0f,
        128'h00112233445566778899aabbccddeeff), 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    run_and_check(128'h000102030405060708090a0b0c0d0e0f,
                  128'h00112233445566778899aabbccddeeff, "fips");

    // directed corners
    run_and_check('0, '0, "zeros");
    run_and_check({128{1'b1}}, {128{1'b1}}, "ones");

    // back-to-back: start on the falling edge right after done
    for (int n = 0; n < 24; n++) run_and_check(rnd128(), rnd128(), "random");

    // R5 restart mid-run
    ka = rnd128(); pa = rnd128(); kb = rnd128(); pb = rnd128();
    kick(ka, pa);
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      chk("R5 no done before restart", {127'd0, done_o}, 128'd0);
    end
    run_and_check(kb, pb, "R5 restart");

    // R5 restart on the final busy cycle
    kick(ka, pa);
    repeat (10) @(negedge clk);
    run_and_check(kb, pb, "R5 late restart");

    // R6 reset mid-run abandons the operation
    kick(ka, pa);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R6 cipher cleared", cipher_o, 128'd0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R6 abandoned run silent", {127'd0, done_o}, 128'd0);
    end
    run_and_check(ka, pa, "after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule